// File: doc/BRIEF.md
# Flash Data-Poll Completion Monitor

This block is a bus master that watches a flash device once a program or erase command has been written to it. It takes a start pulse with the operation kind, the address to poll and the byte that was written. It then runs read cycles on a parallel byte bus until bit 7 of the returned byte shows that the operation has finished. Each read cycle drives the address, pulls the active-low output enable down for a fixed number of cycles and samples the data. The block then reports completion and the final byte to the system logic that started it.

Bit 7 can change from status to real data partway through a read, and on that same read bits 6..0 may still hold stale status. For this reason, when the block first sees completion it always performs one more full read, and the byte it reports comes from that second read. A bound on the number of polling reads stops the block from waiting forever: if completion is never seen, it finishes with an error flag set.

Top module: `dpoll_ctrl`

## Requirements
- R1: During and just after reset, `bus_oe_n_o` is 1, `busy_o`, `done_o` and `err_o` are 0, and `result_o` is 0.
- R2: On every cycle where `bus_oe_n_o` is 0, `bus_addr_o` equals the `addr_i` value captured with the accepted start.
- R3: A read holds `bus_oe_n_o` low for OE_CYCLES+1 consecutive cycles and samples `bus_data_i` at the end of the last low cycle. `bus_oe_n_o` is high for at least one cycle between reads, and is always high while the block is idle.
- R4: When `op_i` is 0 (program), a polling read counts as complete when its bit 7 equals bit 7 of `data_i`.
- R5: When `op_i` is 1 (erase), a polling read counts as complete when its bit 7 is 1, and `data_i` has no effect on the outcome.
- R6: After the first complete polling read, the block performs exactly one more full read, and `result_o` holds the byte from that confirming read.
- R7: `done_o` is high for exactly one cycle. On success this is the cycle right after the last low cycle of the confirming read. `busy_o` is high from the cycle after the start up to and including the `done_o` cycle.
- R8: If MAX_POLLS polling reads in a row are not complete, the block asserts `done_o` with `err_o` = 1 and `result_o` = the last polled byte, and makes no confirming read.
- R9: `result_o` and `err_o` keep their values while the block is idle. Both are cleared to 0 when a start is accepted.
- R10: A `start_i` pulse while `busy_o` is 1 is ignored: the address, operation and expected byte of the running poll do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted only while idle |
| op_i | input | 1 | 0 = program, 1 = erase |
| addr_i | input | ADDR_W | Address to poll |
| data_i | input | 8 | Byte that was programmed |
| bus_addr_o | output | ADDR_W | Address driven to the flash bus |
| bus_oe_n_o | output | 1 | Active-low output enable to the flash |
| bus_data_i | input | 8 | Byte returned by the flash |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Poll limit reached without completion |
| result_o | output | 8 | Final byte, held until the next start |

## Verification
Two pairs of events can land in the same cycle. First, a stray `start_i` pulse can arrive while a read cycle is driving the bus. The bench sends one partway through a poll, using a different address and operation, and its per-cycle model judges the result through `bus_addr_o` and the final outcome. Second, completion can be detected on the very first polling read, so the check and the confirming read follow each other immediately. The bench also runs a program poll whose expected bit 7 is 1 and whose first byte already matches. It then confirms that `result_o` takes the byte from the second read, whose bit 7 is 0, and not from the matching one.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;

    localparam int BYTE_W     = 8;
    localparam int STATUS_BIT = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_ASSERT,
        ST_SAMPLE,
        ST_CHECK,
        ST_CONFIRM_READ,
        ST_DONE
    } poll_state_e;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_kind_e;

    typedef struct packed {
        op_kind_e          op;
        logic [BYTE_W-1:0] expect_byte;
    } poll_job_t;

    function automatic logic poll_met(op_kind_e op, logic expect_msb, logic read_msb);
        if (op == OP_ERASE) begin
            return read_msb;
        end
        return read_msb == expect_msb;
    endfunction

endpackage

// File: rtl/dpoll_oe_timer.sv
module dpoll_oe_timer #(
    parameter int OE_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic hold_done_o,
    output logic read_done_o
);
    localparam int CW = $clog2(OE_CYCLES + 1) + 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hold_done_o = run_i && (cnt_q == CW'(OE_CYCLES - 1));
    assign read_done_o = run_i && (cnt_q == CW'(OE_CYCLES));
endmodule

// File: rtl/dpoll_attempts.sv
module dpoll_attempts #(
    parameter int MAX_POLLS = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int NW = $clog2(MAX_POLLS + 1) + 1;

    logic [NW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o = (cnt_q == NW'(MAX_POLLS - 1));
endmodule

// File: rtl/dpoll_judge.sv
module dpoll_judge
    import dpoll_pkg::*;
(
    input  op_kind_e op_i,
    input  logic     expect_msb_i,
    input  logic     sample_msb_i,
    output logic     met_o
);
    always_comb begin
        met_o = poll_met(op_i, expect_msb_i, sample_msb_i);
    end
endmodule

// File: rtl/dpoll_ctrl.sv
module dpoll_ctrl
    import dpoll_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int OE_CYCLES = 3,
    parameter int MAX_POLLS = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_oe_n_o,
    input  logic [7:0]        bus_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [7:0]        result_o
);
    poll_state_e       state_q;
    poll_job_t         job_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] sample_q;
    logic [BYTE_W-1:0] result_q;
    logic              err_q;

    logic timer_run, hold_done, read_done;
    logic attempts_clear, attempts_inc, attempts_last;
    logic met;
    logic accept;

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign timer_run = (state_q == ST_READ_ASSERT) || (state_q == ST_CONFIRM_READ);

    dpoll_oe_timer #(.OE_CYCLES(OE_CYCLES)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .run_i       (timer_run),
        .hold_done_o (hold_done),
        .read_done_o (read_done)
    );

    dpoll_judge u_judge (
        .op_i         (job_q.op),
        .expect_msb_i (job_q.expect_byte[STATUS_BIT]),
        .sample_msb_i (sample_q[STATUS_BIT]),
        .met_o        (met)
    );

    assign attempts_clear = accept;
    assign attempts_inc   = (state_q == ST_CHECK) && !met && !attempts_last;

    dpoll_attempts #(.MAX_POLLS(MAX_POLLS)) u_attempts (
        .clk     (clk),
        .rst     (rst),
        .clear_i (attempts_clear),
        .inc_i   (attempts_inc),
        .last_o  (attempts_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            job_q    <= '{op: OP_PROGRAM, expect_byte: '0};
            addr_q   <= '0;
            sample_q <= '0;
            result_q <= '0;
            err_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        job_q.op          <= op_kind_e'(op_i);
                        job_q.expect_byte <= data_i;
                        addr_q            <= addr_i;
                        result_q          <= '0;
                        err_q             <= 1'b0;
                        state_q           <= ST_READ_ASSERT;
                    end
                end
                ST_READ_ASSERT: begin
                    if (hold_done) begin
                        state_q <= ST_SAMPLE;
                    end
                end
                ST_SAMPLE: begin
                    sample_q <= bus_data_i;
                    state_q  <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (met) begin
                        state_q <= ST_CONFIRM_READ;
                    end else if (attempts_last) begin
                        result_q <= sample_q;
                        err_q    <= 1'b1;
                        state_q  <= ST_DONE;
                    end else begin
                        state_q <= ST_READ_ASSERT;
                    end
                end
                ST_CONFIRM_READ: begin
                    if (read_done) begin
                        result_q <= bus_data_i;
                        state_q  <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign bus_addr_o = addr_q;
    assign bus_oe_n_o = !((state_q == ST_READ_ASSERT) || (state_q == ST_SAMPLE) ||
                          (state_q == ST_CONFIRM_READ));
    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = (state_q == ST_DONE);
    assign err_o      = err_q;
    assign result_o   = result_q;
endmodule

// File: rtl/dpoll_ctrl_chk.sv
module dpoll_ctrl_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic              bus_oe_n_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic [7:0]        result_o
);
    a_r2_addr_steady: assert property (@(posedge clk) disable iff (rst)
        (!bus_oe_n_o && $past(!bus_oe_n_o)) |-> $stable(bus_addr_o));

    a_r3_oe_idle: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> bus_oe_n_o);

    a_r6_confirm_before_done: assert property (@(posedge clk) disable iff (rst)
        (done_o && !err_o) |-> $past(!bus_oe_n_o));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r8_err_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> done_o);

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(result_o) && $stable(err_o)));

    a_r10_addr_locked: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(bus_addr_o));
endmodule

bind dpoll_ctrl dpoll_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .bus_addr_o (bus_addr_o),
    .bus_oe_n_o (bus_oe_n_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .result_o   (result_o)
);

// File: tb/tb_dpoll_ctrl.sv
module tb_dpoll_ctrl;
    localparam int AW  = 16;
    localparam int OEC = 2;
    localparam int MP  = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic          op;
    logic [AW-1:0] addr;
    logic [7:0]    exp_b;
    logic [AW-1:0] bus_addr;
    logic          oe_n;
    logic [7:0]    bus_data;
    logic          busy, done, err;
    logic [7:0]    result;

    always #4 clk = ~clk;

    dpoll_ctrl #(.ADDR_W(AW), .OE_CYCLES(OEC), .MAX_POLLS(MP)) dut (
        .clk(clk), .rst(rst), .start_i(start), .op_i(op), .addr_i(addr),
        .data_i(exp_b), .bus_addr_o(bus_addr), .bus_oe_n_o(oe_n),
        .bus_data_i(bus_data), .busy_o(busy), .done_o(done), .err_o(err),
        .result_o(result)
    );

    // flash stub: one byte per read cycle
    logic [7:0] stub_mem [0:31];
    int         rd_idx;
    logic       oe_was_low;
    assign bus_data = oe_n ? 8'h00 : stub_mem[rd_idx];

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, expv);
        end
    endtask

    // behavioural reference: mode 0 idle, 1 poll read, 2 judge, 3 confirm read, 4 done
    int            m_mode;
    int            m_cnt;
    int            m_polls;
    bit            m_op;
    logic [7:0]    m_exp;
    logic [AW-1:0] m_addr;
    logic [7:0]    m_sample;
    logic [7:0]    m_res;
    bit            m_err;

    always @(posedge clk) begin
        if (rst) begin
            m_mode <= 0; m_cnt <= 0; m_polls <= 0; m_res <= 8'h00; m_err <= 1'b0;
            m_op <= 1'b0; m_exp <= 8'h00; m_addr <= '0; m_sample <= 8'h00;
        end else begin
            case (m_mode)
                0: if (start) begin
                    m_op <= op; m_exp <= exp_b; m_addr <= addr;
                    m_res <= 8'h00; m_err <= 1'b0; m_polls <= 0; m_cnt <= 0; m_mode <= 1;
                end
                1: if (m_cnt == OEC) begin
                    m_sample <= bus_data; m_mode <= 2;
                end else m_cnt <= m_cnt + 1;
                2: begin
                    if (m_op ? m_sample[7] : (m_sample[7] == m_exp[7])) begin
                        m_mode <= 3; m_cnt <= 0;
                    end else if (m_polls == MP - 1) begin
                        m_res <= m_sample; m_err <= 1'b1; m_mode <= 4;
                    end else begin
                        m_polls <= m_polls + 1; m_mode <= 1; m_cnt <= 0;
                    end
                end
                3: if (m_cnt == OEC) begin
                    m_res <= bus_data; m_mode <= 4;
                end else m_cnt <= m_cnt + 1;
                default: m_mode <= 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(oe_n == !(m_mode == 1 || m_mode == 3), "R3", "oe_n", oe_n, !(m_mode == 1 || m_mode == 3));
            chk(busy == (m_mode != 0), "R7", "busy", busy, m_mode != 0);
            chk(done == (m_mode == 4), "R7", "done", done, m_mode == 4);
            chk(err == m_err, "R8", "err", err, m_err);
            chk(result == m_res, "R6", "result", result, m_res);
            if (!oe_n) chk(bus_addr == m_addr, "R2", "bus_addr", bus_addr, m_addr);
        end
        if (oe_was_low && oe_n && rd_idx < 31) rd_idx = rd_idx + 1;
        oe_was_low = !oe_n;
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load_fill(input logic [7:0] v);
        for (int i = 0; i < 32; i++) stub_mem[i] = v;
        rd_idx = 0;
    endtask

    task automatic issue(input bit o, input logic [AW-1:0] a, input logic [7:0] d);
        op = o; addr = a; exp_b = d; start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag, input logic [7:0] want_res, input bit want_err);
        bit seen = 0;
        for (int i = 0; i < 500 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        chk(seen, tag, "done seen", seen, 1);
        chk(result == want_res, tag, "final result", result, want_res);
        chk(err == want_err, tag, "final err", err, want_err);
        @(negedge clk);
        chk(!done, "R7", "done one cycle", done, 0);
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL R7 watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; op = 1'b0; addr = '0; exp_b = 8'h00;
        oe_was_low = 1'b0;
        load_fill(8'h00);
        repeat (3) tick();
        chk(oe_n && !busy && !done && !err && result == 8'h00, "R1", "reset outputs",
            {oe_n, busy, done, err, result}, {1'b1, 3'b000, 8'h00});
        rst = 1'b0;
        @(negedge clk);
        chk(oe_n && !busy && !done && !err && result == 8'h00, "R1", "after reset",
            {oe_n, busy, done, err, result}, {1'b1, 3'b000, 8'h00});
        tick();

        // R4/R6: program, bit7 of 0x5A is 0; 0x25 matches with stale low bits
        load_fill(8'h5A);
        stub_mem[0] = 8'hA5; stub_mem[1] = 8'hA5; stub_mem[2] = 8'h25; stub_mem[3] = 8'h5A;
        issue(1'b0, 16'h1234, 8'h5A);
        wait_done("R4", 8'h5A, 1'b0);
        repeat (2) tick();

        // R10: stray start during poll must be ignored
        load_fill(8'hC3);
        stub_mem[0] = 8'h00; stub_mem[1] = 8'h80; stub_mem[2] = 8'hC3;
        issue(1'b0, 16'h0F0F, 8'hC3);
        repeat (3) tick();
        issue(1'b1, 16'hAAAA, 8'h00);
        @(negedge clk);
        chk(bus_addr == 16'h0F0F, "R10", "address after stray start", bus_addr, 16'h0F0F);
        wait_done("R10", 8'hC3, 1'b0);
        repeat (2) tick();

        // R5: erase, expected byte bit7=0 has no effect
        load_fill(8'hFF);
        stub_mem[0] = 8'h00; stub_mem[1] = 8'h12; stub_mem[2] = 8'h80; stub_mem[3] = 8'hFF;
        issue(1'b1, 16'h3000, 8'h00);
        wait_done("R5", 8'hFF, 1'b0);
        repeat (2) tick();

        // R8: never completes
        load_fill(8'h80);
        issue(1'b0, 16'h0042, 8'h00);
        wait_done("R8", 8'h80, 1'b1);

        // R9: held while idle
        repeat (5) tick();
        @(negedge clk);
        chk(err == 1'b1, "R9", "err held", err, 1);
        chk(result == 8'h80, "R9", "result held", result, 8'h80);
        tick();

        // R6: completion on first read, confirm byte differs in bit7
        load_fill(8'h7E);
        stub_mem[0] = 8'h80;
        issue(1'b0, 16'h0777, 8'h80);
        @(negedge clk);
        chk(!err && result == 8'h00, "R9", "cleared on start", {err, result}, 9'h000);
        wait_done("R6", 8'h7E, 1'b0);
        repeat (3) tick();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule